// File: doc/BRIEF.md
# Programmable Interrupt Countdown Timer

This block is a down-counting timer that raises an interrupt request when its count runs out. Software programs it through four word registers: a control entry that holds an interrupt vector, a mask flag and a mode flag, a start value, a divider setting, and a read-only view of the live count. The count drops by one on each prescaler tick. The divider setting chooses a tick period of 1 to 128 clock cycles.

The timer has two modes. In one-shot mode it counts down from the start value, gives one request after the tick that follows zero, and then stays at zero. In periodic mode it runs through the start value plus one states and reloads itself each time, which gives a request every (start+1) ticks. Each request is a one-cycle pulse, and the programmed vector is valid in the same cycle. A start value of zero keeps the timer idle in both modes. A new write of the start value always restarts the timer.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the control entry reads 0x0001_0000 (masked, one-shot, vector 0). The start value, the current count and the divider setting read 0, and no pulse is given.
- R2: Register select codes: 0 is the control entry, 1 is the start value, 2 is the current count and 3 is the divider. A write to the control entry keeps bits 17, 16 and 7:0 only. A write to the divider keeps bits 3, 1 and 0 only (mask 0xB). A write to select code 2 changes nothing.
- R3: The divider code is {bit3, bit1, bit0}. The count moves once every 2^((code+1) mod 8) clock cycles, so code 7 ticks every cycle and code 0 ticks every second cycle. The prescaler phase starts again from the edge that writes the start value.
- R4: A write of start value N makes the current count read N in the next cycle. The timer then runs again from N.
- R5: While the count is non-zero, each tick lowers it by exactly one.
- R6: One-shot mode (bit 17 clear): the tick that finds the count at zero gives one pulse. After that the count stays at zero and no further pulse comes until the start value is written again.
- R7: Periodic mode (bit 17 set): the tick that finds the count at zero reloads the start value and gives a pulse. Pulses are then (N+1)·D cycles apart, where D is the tick period.
- R8: A start value of zero never produces a pulse, in either mode, and the count stays at zero.
- R9: An expiry while bit 16 is set gives no pulse. Counting and reloading go on unchanged.
- R10: The pulse lasts one cycle. It is high in the cycle after the clock edge of the expiring tick, and the output vector in that cycle equals bits 7:0 of the entry that applied at that tick.
- R11: A rewrite of the control entry does not change the running count. The new vector and mask apply to expiries on later edges.
- R12: If a start-value write lands on the same edge as an expiry, the write wins: no pulse is given and the count reads the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Register select for the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector that goes with irq_pulse |

## Verification
Two events can fall on the same clock edge: a software write of the start value and the tick that expires the old count. The bench counts cycles from a first write, then times a second write onto the exact expiry edge at the fastest divider. It expects no pulse on that edge, the new count in the next cycle, and a pulse after the full new interval. A second case of this kind writes the control entry on the edge just before an expiry. There the vector and mask must change while the count follows the uninterrupted model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int SHIFT_W = 3;
  localparam int PRE_W   = (1 << SHIFT_W) - 1;

  typedef enum logic [1:0] {
    SEL_ENTRY = 2'd0,
    SEL_START = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_DIV   = 2'd3
  } reg_sel_e;

  localparam int MODE_BIT = 17;
  localparam int MASK_BIT = 16;
  localparam int VEC_W    = 8;

  localparam logic [31:0] ENTRY_KEEP  = 32'h0003_00FF;
  localparam logic [31:0] ENTRY_RESET = 32'h0001_0000;
  localparam logic [31:0] DIV_KEEP    = 32'h0000_000B;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vector;
  } entry_t;

  function automatic entry_t unpack_entry(input logic [31:0] raw);
    entry_t e;
    e.periodic = raw[MODE_BIT];
    e.masked   = raw[MASK_BIT];
    e.vector   = raw[VEC_W-1:0];
    return e;
  endfunction

  function automatic logic [SHIFT_W-1:0] div_code(input logic [31:0] cfg);
    return {cfg[3], cfg[1], cfg[0]};
  endfunction

  function automatic logic [SHIFT_W-1:0] div_shift(input logic [SHIFT_W-1:0] code);
    return code + 3'd1;
  endfunction

  function automatic logic [PRE_W-1:0] phase_mask(input logic [SHIFT_W-1:0] sh);
    logic [PRE_W:0] full;
    full = ({{PRE_W{1'b0}}, 1'b1} << sh) - 1'b1;
    return full[PRE_W-1:0];
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);

  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] sel_mask;

  always_comb sel_mask = phase_mask(shift);

  assign tick = ((phase_q & sel_mask) == sel_mask);

  always_ff @(posedge clk) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else              phase_q <= phase_q + 1'b1;
  end

endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] count_q,
  output logic             armed_q,
  output logic             expire
);

  logic at_zero;

  assign at_zero = (count_q == '0);
  assign expire  = tick & armed_q & at_zero & ~load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      count_q <= load_val;
      armed_q <= (load_val != '0);
    end else if (tick && armed_q) begin
      if (!at_zero)      count_q <= count_q - 1'b1;
      else if (periodic) count_q <= reload_val;
      else               armed_q <= 1'b0;
    end
  end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  input  logic [CNT_W-1:0]  count_now,
  output logic [DATA_W-1:0] rd_data,
  output logic [31:0]       entry_q,
  output logic [CNT_W-1:0]  start_q,
  output logic [31:0]       div_q,
  output logic              start_wr
);

  logic [31:0] wr_word;

  assign wr_word  = 32'(wr_data);
  assign start_wr = wr_en && (reg_sel_e'(wr_addr) == SEL_START);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_q <= ENTRY_RESET;
      start_q <= '0;
      div_q   <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_addr))
        SEL_ENTRY: entry_q <= wr_word & ENTRY_KEEP;
        SEL_START: start_q <= CNT_W'(wr_data);
        SEL_DIV:   div_q   <= wr_word & DIV_KEEP;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel_e'(rd_addr))
      SEL_ENTRY: rd_data = DATA_W'(entry_q);
      SEL_START: rd_data = DATA_W'(start_q);
      SEL_COUNT: rd_data = DATA_W'(count_now);
      default:   rd_data = DATA_W'(div_q);
    endcase
  end

endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_pulse,
  output logic [VEC_W-1:0]  irq_vector
);

  logic [31:0]        entry_q;
  logic [31:0]        div_q;
  logic [CNT_W-1:0]   start_q;
  logic [CNT_W-1:0]   count_q;
  logic [CNT_W-1:0]   load_val;
  logic               start_wr;
  logic               tick;
  logic               expire;
  logic               armed_q;
  logic [SHIFT_W-1:0] tick_shift;
  entry_t             ent;

  assign ent        = unpack_entry(entry_q);
  assign tick_shift = div_shift(div_code(div_q));
  assign load_val   = CNT_W'(wr_data);

  tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .count_now(count_q),
    .rd_data  (rd_data),
    .entry_q  (entry_q),
    .start_q  (start_q),
    .div_q    (div_q),
    .start_wr (start_wr)
  );

  tmr_prescaler u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(start_wr),
    .shift  (tick_shift),
    .tick   (tick)
  );

  tmr_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_wr),
    .load_val  (load_val),
    .reload_val(start_q),
    .tick      (tick),
    .periodic  (ent.periodic),
    .count_q   (count_q),
    .armed_q   (armed_q),
    .expire    (expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pulse  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_pulse <= expire & ~ent.masked;
      if (expire) irq_vector <= ent.vector;
    end
  end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             expire,
  input logic             start_wr,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] start_q,
  input logic             armed_q,
  input logic             periodic,
  input logic             masked,
  input logic [7:0]       vector,
  input logic             irq_pulse,
  input logic [7:0]       irq_vector
);

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> count_q == $past(load_val));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && armed_q && count_q != '0 && !start_wr) |=> count_q == $past(count_q) - 1'b1);

  assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !periodic) |=> (count_q == '0 && !armed_q));

  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> count_q == $past(start_q));

  assert_zero_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && load_val == '0) |=> !armed_q);

  assert_masked_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && masked) |=> !irq_pulse);

  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  assert_pulse_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> ($past(expire) && irq_vector == $past(vector)));

  assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> !irq_pulse);

endmodule

bind irq_countdown_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .expire    (expire),
  .start_wr  (start_wr),
  .load_val  (load_val),
  .count_q   (count_q),
  .start_q   (start_q),
  .armed_q   (armed_q),
  .periodic  (ent.periodic),
  .masked    (ent.masked),
  .vector    (ent.vector),
  .irq_pulse (irq_pulse),
  .irq_vector(irq_vector)
);

// File: tb/sim_irq_countdown_timer.sv
module sim_irq_countdown_timer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_countdown_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );

  // tick period in cycles, derived from the divider word
  function automatic int exp_div(input logic [31:0] cfg);
    int code;
    code = int'(cfg[3]) * 4 + int'(cfg[1]) * 2 + int'(cfg[0]);
    return 1 << ((code + 1) % 8);
  endfunction

  // expected count k cycles after the start write edge
  function automatic longint exp_count(input longint n, input bit per, input int k, input int d);
    longint t;
    t = k / d;
    if (per) return (n == 0) ? 0 : n - (t % (n + 1));
    return (t >= n) ? 0 : n - t;
  endfunction

  // does an expiry happen on the edge k cycles after the start write
  function automatic bit exp_fire(input longint n, input bit per, input int k, input int d);
    longint t;
    if (n == 0 || k == 0 || (k % d) != 0) return 1'b0;
    t = k / d;
    return per ? ((t % (n + 1)) == 0) : (t == n + 1);
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
    rd_addr = 2'd2;
  endtask

  task automatic run_case(input string tag, input logic [31:0] cfg, input logic [31:0] entry,
                          input logic [31:0] n, input int kw, input logic [31:0] entry2,
                          input int cycles);
    int d;
    bit per;
    bit cnt_bad, pul_bad;
    logic [31:0] cnt_act, cnt_exp;
    logic [7:0] vec_act, vec_exp;
    logic pul_act, pul_exp;
    int bad_k_c, bad_k_p;
    d = exp_div(cfg);
    per = entry[17];
    cnt_bad = 0; pul_bad = 0; bad_k_c = 0; bad_k_p = 0;
    cnt_act = 0; cnt_exp = 0; vec_act = 0; vec_exp = 0; pul_act = 0; pul_exp = 0;
    reg_write(2'd3, cfg);
    reg_write(2'd0, entry);
    reg_write(2'd1, n);
    rd_addr = 2'd2;
    for (int k = 0; k <= cycles; k++) begin
      logic [31:0] eff;
      logic e_pul;
      if (k > 0) begin
        @(posedge clk);
        @(negedge clk);
      end
      if (kw >= 0 && k == kw + 1) wr_en = 1'b0;
      eff = (kw >= 0 && k >= kw + 2) ? entry2 : entry;
      #1;
      if (!cnt_bad && rd_data !== 32'(exp_count(longint'(n), per, k, d))) begin
        cnt_bad = 1; bad_k_c = k; cnt_act = rd_data; cnt_exp = 32'(exp_count(longint'(n), per, k, d));
      end
      e_pul = exp_fire(longint'(n), per, k, d) && !eff[16];
      if (!pul_bad && (irq_pulse !== e_pul || (e_pul && irq_vector !== eff[7:0]))) begin
        pul_bad = 1; bad_k_p = k; pul_act = irq_pulse; pul_exp = e_pul;
        vec_act = irq_vector; vec_exp = eff[7:0];
      end
      if (kw >= 0 && k == kw) begin
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = entry2;
      end
    end
    checks += 2;
    if (cnt_bad) begin
      errors++;
      $display("FAIL %s count at cycle %0d: actual %0d expected %0d", tag, bad_k_c, cnt_act, cnt_exp);
    end
    if (pul_bad) begin
      errors++;
      $display("FAIL %s pulse at cycle %0d: actual %0b/0x%02h expected %0b/0x%02h",
               tag, bad_k_p, pul_act, vec_act, pul_exp, vec_exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 190000 cycles expected completion earlier");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int unsigned seed;
    seed = $urandom(32'd4711);
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = '0; rd_addr = 2'd2;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    reg_read(2'd0, v); check32("R1 entry", v, 32'h0001_0000);
    reg_read(2'd1, v); check32("R1 start", v, 32'h0);
    reg_read(2'd2, v); check32("R1 count", v, 32'h0);
    reg_read(2'd3, v); check32("R1 divider", v, 32'h0);
    check32("R1 pulse", {31'd0, irq_pulse}, 32'h0);

    // R2 write masks and read-only count
    reg_write(2'd0, 32'hFFFF_FFFF); reg_read(2'd0, v); check32("R2 entry mask", v, 32'h0003_00FF);
    reg_write(2'd3, 32'hFFFF_FFFF); reg_read(2'd3, v); check32("R2 divider mask", v, 32'h0000_000B);
    reg_write(2'd0, 32'h0001_0000);
    reg_write(2'd3, 32'h0000_000A);
    reg_write(2'd1, 32'd100);
    reg_write(2'd2, 32'h55);
    reg_read(2'd2, v); check32("R2 count write ignored", v, 32'd100);
    reg_read(2'd1, v); check32("R2 start readback", v, 32'd100);

    // directed modes and dividers
    run_case("R3 R4 R5 R6 R10 oneshot div1", 32'hB, 32'h0000_0031, 32'd4, -1, 0, 14);
    run_case("R3 R7 periodic div2", 32'h0, 32'h0002_0042, 32'd3, -1, 0, 26);
    run_case("R3 R7 periodic div16", 32'h3, 32'h0002_0017, 32'd2, -1, 0, 100);
    run_case("R3 R6 oneshot div128", 32'hA, 32'h0000_0080, 32'd1, -1, 0, 520);
    run_case("R8 periodic zero", 32'hB, 32'h0002_0011, 32'd0, -1, 0, 40);
    run_case("R8 oneshot zero", 32'hB, 32'h0000_0011, 32'd0, -1, 0, 40);
    run_case("R9 masked then open", 32'hB, 32'h0003_0066, 32'd2, 5, 32'h0002_0067, 20);
    run_case("R11 vector rewrite", 32'hB, 32'h0002_0011, 32'd3, 2, 32'h0002_0099, 16);

    // R12 start write on the expiry edge
    reg_write(2'd3, 32'hB);
    reg_write(2'd0, 32'h0000_0021);
    reg_write(2'd1, 32'd3);
    repeat (3) begin @(posedge clk); @(negedge clk); end
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'd5;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    #1;
    check32("R12 no pulse on collision", {31'd0, irq_pulse}, 32'h0);
    check32("R12 count takes new value", rd_data, 32'd5);
    repeat (5) begin @(posedge clk); @(negedge clk); end
    check32("R12 no early pulse", {31'd0, irq_pulse}, 32'h0);
    @(posedge clk); @(negedge clk);
    check32("R12 later pulse", {31'd0, irq_pulse}, 32'h1);
    check32("R12 later vector", {24'd0, irq_vector}, 32'h21);

    // random mix
    for (int i = 0; i < 16; i++) begin
      logic [31:0] cfg, ent, ent2, n;
      int kw, cyc;
      cfg  = $urandom;
      n    = $urandom % 10;
      ent  = $urandom & 32'h0003_00FF;
      if (($urandom % 4) != 0) ent[16] = 1'b0;
      ent2 = ($urandom & 32'h0001_00FF) | (ent & 32'h0002_0000);
      cyc  = 2 * (int'(n) + 1) * exp_div(cfg) + 4;
      kw   = (($urandom % 2) == 0) ? -1 : int'($urandom % 32'(cyc));
      run_case("R3 R5 R6 R7 R9 R10 R11 random", cfg, ent, n, kw, ent2, cyc);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule